// File: doc/BRIEF.md
# Interrupt, Halt and Soft-Reset Controller for a Dual I2C Master

This block is the status and recovery unit for a controller with two I2C masters, each owning two command queues. The masters' bit engines are modelled only as event sources. Completion events, halt and reset acknowledges, and error events from both masters are folded into one 32-bit sticky status word. A 32-bit enable mask selects which status bits may raise the single interrupt line. Software clears status bits with a write-one-to-clear register. The interrupt line then stays asserted until a separate release write, and the release only takes effect when no enabled bit is still pending.

Recovery follows a halt-then-reset handshake. Writing a master's bit to the halt register stops both of that master's queues at once. After a programmable drain delay, the master's halt-acknowledge status bit is set. A soft-reset command word resets master 0, master 1 or both. It releases the halted queues and, once finished, sets the reset-done status bit.

Each master has its own halt state machine with three states: RUN, DRAIN and HALTED. The transitions are:
- RUN to DRAIN on a halt request.
- DRAIN to HALTED when the drain counter expires; the acknowledge is raised on this transition.
- Any state back to RUN when that master is reset.

The reset sequencer has three states, IDLE, APPLY and DONE:
- IDLE to APPLY when a recognised command word arrives.
- APPLY to DONE after the reset has been held for the programmed length.
- DONE to IDLE after one cycle, during which it reports completion.

The interrupt state machine has two states, QUIET and RAISED:
- QUIET to RAISED when any enabled status bit is pending.
- RAISED to QUIET only on a release write while nothing enabled is pending.

Register word addresses on `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | status | read |
| 1 | mask | read and write |
| 2 | clear | write |
| 3 | release | write |
| 4 | halt (reads back the current queue_stop) | write and read |
| 5 | reset command | write |

Top module: `irq_recovery_ctl`

## Requirements
- R1: Completion events land in the status word at fixed positions. Master m (m = 0 or 1) uses base 12*m: read-done at base+0, queue 0 report at base+4, queue 1 report at base+8. Master 0 therefore uses bits 0, 4 and 8, and master 1 uses bits 12, 16 and 20.
- R2: NACK errors set bits 27, 28, 29 and 30, for master 0 queue 0, master 0 queue 1, master 1 queue 0 and master 1 queue 1 respectively. Each master has eight other fault inputs, `ev_fault[8*m+i]`, which map to base+{1,2,5,6,7,9,10,11} in index order. The resulting error groups are 0x18000EE6 for master 0 and 0x60EE6000 for master 1.
- R3: A write to the clear register clears exactly the status bits set in the written value and leaves the others unchanged. An event arriving in the same cycle as the clear of its own bit leaves that bit set.
- R4: The mask resets to zero. The irq output rises only for status bits that are also set in the mask.
- R5: irq stays asserted after the status bits are cleared, until a write with bit 0 set to the release register. A release write while an enabled bit is still set leaves irq asserted.
- R6: Writing bit m to the halt register raises `queue_stop[m]` in the next cycle. Status bit 25+m is set HALT_DLY cycles after the write, and stays clear before then.
- R7: A halt request to a master that is already draining or halted is ignored: no second acknowledge is produced.
- R8: Reset word 0x0F73F3F7 resets both masters, 0x000003F1 resets master 0 and 0x0003F001 resets master 1. The selected `master_rst` bits are asserted from the cycle after the write, the selected masters leave the halted state, and status bit 24 is set when the sequence completes.
- R9: Any other reset word is ignored. `master_rst` stays zero, status bit 24 stays clear and `queue_stop` is unchanged.
- R10: `reg_rvalid` pulses one cycle after `reg_rd`, with the addressed register in `reg_rdata`. The mask reads back as written, address 4 returns `queue_stop` in bits 1:0, and undecoded addresses return zero.
- R11: After reset, status, mask, irq, `queue_stop` and `master_rst` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ev_rd_done | input | 2 | Read-done event per master |
| ev_q_report | input | 4 | Queue report event, index 2*m+q |
| ev_nack | input | 4 | NACK error, index 2*m+q |
| ev_fault | input | 16 | Other fault events, eight per master |
| queue_stop | output | 2 | Both queues of master m stopped |
| master_rst | output | 2 | Soft reset applied to master m |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check five properties on every cycle:
- irq is high whenever an enabled status bit is set.
- irq only falls after a release write.
- A halt acknowledge only appears while that master's queues are already stopped.
- A master being reset never keeps its queues stopped.
- A clear-all write with no incoming events empties the status word.

The bench scenarios show the properties that need particular stimulus: the exact bit placement of every event group, the clear-versus-event collision, the ignored second halt and bad reset words, and the drain-delay ordering that keeps the acknowledge bit clear right after the halt request.

// File: rtl/irq_rcv_pkg.sv
`timescale 1ns/1ps
package irq_rcv_pkg;
    localparam int NUM_MST     = 2;
    localparam int QPM         = 2;
    localparam int STAT_W      = 32;
    localparam int FAULTS_PM   = 8;
    localparam int MST_STRIDE  = 12;
    localparam int BIT_RST_DONE = 24;
    localparam int BIT_HACK0   = 25;
    localparam int BIT_NACK0   = 27;

    localparam logic [STAT_W-1:0] CMD_RST_ALL = 32'h0F73_F3F7;
    localparam logic [STAT_W-1:0] CMD_RST_M0  = 32'h0000_03F1;
    localparam logic [STAT_W-1:0] CMD_RST_M1  = 32'h0003_F001;

    typedef enum logic [2:0] {
        A_STATUS  = 3'd0,
        A_MASK    = 3'd1,
        A_CLEAR   = 3'd2,
        A_RELEASE = 3'd3,
        A_HALT    = 3'd4,
        A_RESET   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {H_RUN, H_DRAIN, H_HALTED} halt_st_e;
    typedef enum logic [1:0] {S_IDLE, S_APPLY, S_DONE} rst_st_e;
    typedef enum logic {I_QUIET, I_RAISED} irq_st_e;

    // Bit offset, inside one master's field, of its i-th generic fault input
    function automatic int fault_offset(input int i);
        case (i)
            0: return 1;
            1: return 2;
            2: return 5;
            3: return 6;
            4: return 7;
            5: return 9;
            6: return 10;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/irq_event_pack.sv
`timescale 1ns/1ps
module irq_event_pack
    import irq_rcv_pkg::*;
(
    input  logic [NUM_MST-1:0]           rd_done,
    input  logic [NUM_MST*QPM-1:0]       q_report,
    input  logic [NUM_MST*QPM-1:0]       nack,
    input  logic [NUM_MST*FAULTS_PM-1:0] fault,
    input  logic                         rst_done,
    input  logic [NUM_MST-1:0]           halt_ack,
    output logic [STAT_W-1:0]            set_vec
);
    always_comb begin
        set_vec = '0;
        for (int m = 0; m < NUM_MST; m++) begin
            set_vec[m*MST_STRIDE] = rd_done[m];
            for (int q = 0; q < QPM; q++) begin
                set_vec[m*MST_STRIDE + 4 + 4*q] = q_report[m*QPM + q];
                set_vec[BIT_NACK0 + m*QPM + q]  = nack[m*QPM + q];
            end
            for (int f = 0; f < FAULTS_PM; f++) begin
                set_vec[m*MST_STRIDE + fault_offset(f)] = fault[m*FAULTS_PM + f];
            end
            set_vec[BIT_HACK0 + m] = halt_ack[m];
        end
        set_vec[BIT_RST_DONE] = rst_done;
    end
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
    import irq_rcv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic              release_we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);
    irq_st_e           st_q, st_d;
    logic [STAT_W-1:0] status_d, mask_d, clr_bits;
    logic              pending_d;

    always_comb begin
        clr_bits  = clr_we ? wdata : '0;
        status_d  = (status_q & ~clr_bits) | set_vec;
        mask_d    = mask_we ? wdata : mask_q;
        pending_d = |(status_d & mask_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            st_q     <= I_QUIET;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
            st_q     <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            I_QUIET:  if (pending_d) st_d = I_RAISED;
            I_RAISED: if (release_we && !pending_d) st_d = I_QUIET;
            default:  st_d = I_QUIET;
        endcase
    end

    assign irq = (st_q == I_RAISED);
endmodule

// File: rtl/master_halt_fsm.sv
`timescale 1ns/1ps
module master_halt_fsm
    import irq_rcv_pkg::*;
#(
    parameter int HALT_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic soft_rst,
    output logic stop_o,
    output logic ack_o
);
    localparam int CNT_W = (HALT_DLY < 2) ? 1 : $clog2(HALT_DLY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALT_DLY - 1);

    halt_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= H_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        ack_o = 1'b0;
        if (soft_rst) begin
            st_d  = H_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                H_RUN: if (halt_req) begin
                    st_d  = H_DRAIN;
                    cnt_d = '0;
                end
                H_DRAIN: if (cnt_q == CNT_LAST) begin
                    st_d  = H_HALTED;
                    ack_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                H_HALTED: st_d = H_HALTED;
                default:  st_d = H_RUN;
            endcase
        end
    end

    assign stop_o = (st_q != H_RUN);
endmodule

// File: rtl/soft_reset_seq.sv
`timescale 1ns/1ps
module soft_reset_seq
    import irq_rcv_pkg::*;
#(
    parameter int RST_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [STAT_W-1:0]  cmd_word,
    output logic [NUM_MST-1:0] master_rst,
    output logic               done
);
    localparam int CNT_W = (RST_LEN < 2) ? 1 : $clog2(RST_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_LEN - 1);

    rst_st_e            st_q, st_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [NUM_MST-1:0] tgt_q, tgt_d, decoded;

    always_comb begin
        if (cmd_word == CMD_RST_ALL)     decoded = 2'b11;
        else if (cmd_word == CMD_RST_M0) decoded = 2'b01;
        else if (cmd_word == CMD_RST_M1) decoded = 2'b10;
        else                             decoded = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            tgt_q <= tgt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        tgt_d = tgt_q;
        unique case (st_q)
            S_IDLE: if (cmd_we && decoded != '0) begin
                st_d  = S_APPLY;
                cnt_d = '0;
                tgt_d = decoded;
            end
            S_APPLY: if (cnt_q == CNT_LAST) st_d = S_DONE;
                     else cnt_d = cnt_q + 1'b1;
            S_DONE: begin
                st_d  = S_IDLE;
                tgt_d = '0;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        master_rst = (st_q == S_APPLY) ? tgt_q : '0;
        done       = (st_q == S_DONE);
    end
endmodule

// File: rtl/irq_recovery_ctl.sv
`timescale 1ns/1ps
module irq_recovery_ctl
    import irq_rcv_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int HALT_DLY = 4,
    parameter int RST_LEN  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [STAT_W-1:0]            reg_wdata,
    output logic [STAT_W-1:0]            reg_rdata,
    output logic                         reg_rvalid,
    input  logic [NUM_MST-1:0]           ev_rd_done,
    input  logic [NUM_MST*QPM-1:0]       ev_q_report,
    input  logic [NUM_MST*QPM-1:0]       ev_nack,
    input  logic [NUM_MST*FAULTS_PM-1:0] ev_fault,
    output logic [NUM_MST-1:0]           queue_stop,
    output logic [NUM_MST-1:0]           master_rst,
    output logic                         irq
);
    logic [STAT_W-1:0]  status_q, mask_q, set_vec, rd_mux;
    logic [NUM_MST-1:0] halt_ack;
    logic               rst_done;
    logic               we_mask, we_clear, we_release, we_halt, we_reset;

    always_comb begin
        we_mask    = reg_wr && (reg_addr == ADDR_W'(A_MASK));
        we_clear   = reg_wr && (reg_addr == ADDR_W'(A_CLEAR));
        we_release = reg_wr && (reg_addr == ADDR_W'(A_RELEASE)) && reg_wdata[0];
        we_halt    = reg_wr && (reg_addr == ADDR_W'(A_HALT));
        we_reset   = reg_wr && (reg_addr == ADDR_W'(A_RESET));
    end

    irq_event_pack u_pack (
        .rd_done  (ev_rd_done),
        .q_report (ev_q_report),
        .nack     (ev_nack),
        .fault    (ev_fault),
        .rst_done (rst_done),
        .halt_ack (halt_ack),
        .set_vec  (set_vec)
    );

    irq_status_unit u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_we     (we_clear),
        .mask_we    (we_mask),
        .release_we (we_release),
        .wdata      (reg_wdata),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    soft_reset_seq #(.RST_LEN(RST_LEN)) u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (we_reset),
        .cmd_word   (reg_wdata),
        .master_rst (master_rst),
        .done       (rst_done)
    );

    for (genvar m = 0; m < NUM_MST; m++) begin : g_halt
        master_halt_fsm #(.HALT_DLY(HALT_DLY)) u_hfsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .halt_req (we_halt && reg_wdata[m]),
            .soft_rst (master_rst[m]),
            .stop_o   (queue_stop[m]),
            .ack_o    (halt_ack[m])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(A_STATUS))    rd_mux = status_q;
        else if (reg_addr == ADDR_W'(A_MASK)) rd_mux = mask_q;
        else if (reg_addr == ADDR_W'(A_HALT)) rd_mux = STAT_W'(queue_stop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/irq_recovery_chk.sv
`timescale 1ns/1ps
module irq_recovery_chk
    import irq_rcv_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [STAT_W-1:0]   reg_wdata,
    input logic [STAT_W-1:0]   status_q,
    input logic [STAT_W-1:0]   mask_q,
    input logic [STAT_W-1:0]   set_vec,
    input logic [NUM_MST-1:0]  queue_stop,
    input logic [NUM_MST-1:0]  master_rst,
    input logic                irq
);
    // R4
    pending_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask_q)) |-> irq);

    // R5
    irq_release_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == ADDR_W'(A_RELEASE) && reg_wdata[0]));

    // R6
    halt0_ack_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_HACK0]) |-> $past(queue_stop[0]));

    // R6
    halt1_ack_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_HACK0+1]) |-> $past(queue_stop[1]));

    // R8
    reset_releases_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|master_rst) |=> ((queue_stop & $past(master_rst)) == '0));

    // R3
    clear_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_CLEAR) && reg_wdata == '1 && set_vec == '0)
        |=> (status_q == '0));
endmodule

bind irq_recovery_ctl irq_recovery_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .set_vec    (set_vec),
    .queue_stop (queue_stop),
    .master_rst (master_rst),
    .irq        (irq)
);

// File: tb/sim_irq_recovery_ctl.sv
`timescale 1ns/1ps
module sim_irq_recovery_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [1:0]  ev_rd_done = '0;
    logic [3:0]  ev_q_report = '0, ev_nack = '0;
    logic [15:0] ev_fault = '0;
    logic [1:0]  queue_stop, master_rst;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irq_recovery_ctl #(.ADDR_W(3), .HALT_DLY(4), .RST_LEN(2)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .ev_rd_done(ev_rd_done), .ev_q_report(ev_q_report),
        .ev_nack(ev_nack), .ev_fault(ev_fault), .queue_stop(queue_stop),
        .master_rst(master_rst), .irq(irq)
    );

    // Scoreboard monitor: each read result is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: unexpected read data %h expected none", reg_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic ev(input logic [1:0] rd, input logic [3:0] qr,
                      input logic [3:0] nk, input logic [15:0] ft);
        @(negedge clk); ev_rd_done = rd; ev_q_report = qr; ev_nack = nk; ev_fault = ft;
        @(negedge clk); ev_rd_done = '0; ev_q_report = '0; ev_nack = '0; ev_fault = '0;
    endtask

    task automatic clr_all();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk(32'(irq), 0, "R11 irq");
        chk(32'(queue_stop), 0, "R11 queue_stop");
        chk(32'(master_rst), 0, "R11 master_rst");
        rd_exp(3'd0, 32'h0, "R11 status");
        rd_exp(3'd1, 32'h0, "R11 mask");

        // R1 completion bit positions, R4 mask zero keeps irq low
        ev(2'b11, 4'b1111, 4'b0000, 16'h0000);
        rd_exp(3'd0, 32'h0011_1111, "R1 completion bits");
        chk(32'(irq), 0, "R4 irq masked");
        clr_all();
        rd_exp(3'd0, 32'h0, "R3 clear all");

        // R2 error groups
        ev(2'b00, 4'b0000, 4'b0011, 16'h00FF);
        rd_exp(3'd0, 32'h1800_0EE6, "R2 master0 error group");
        clr_all();
        ev(2'b00, 4'b0000, 4'b1100, 16'hFF00);
        rd_exp(3'd0, 32'h60EE_6000, "R2 master1 error group");
        clr_all();
        ev(2'b00, 4'b0000, 4'b0100, 16'h0000);
        rd_exp(3'd0, 32'h2000_0000, "R2 nack m1q0 bit29");
        clr_all();

        // R3 partial clear and collision
        ev(2'b11, 4'b1111, 4'b0000, 16'h0000);
        wr(3'd2, 32'h0000_0011);
        rd_exp(3'd0, 32'h0011_1100, "R3 partial clear");
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1; ev_rd_done = 2'b01;
        @(negedge clk); reg_wr = 1'b0; ev_rd_done = 2'b00;
        rd_exp(3'd0, 32'h0011_1101, "R3 event during clear kept");
        clr_all();

        // R4 / R5 interrupt behaviour
        wr(3'd1, 32'h0000_0010);
        rd_exp(3'd1, 32'h0000_0010, "R10 mask readback");
        ev(2'b01, 4'b0000, 4'b0000, 16'h0000);
        chk(32'(irq), 0, "R4 unmasked bit no irq");
        ev(2'b00, 4'b0001, 4'b0000, 16'h0000);
        chk(32'(irq), 1, "R4 masked bit raises irq");
        wr(3'd3, 32'h1);
        chk(32'(irq), 1, "R5 release while pending");
        wr(3'd2, 32'hFFFF_FFFF);
        chk(32'(irq), 1, "R5 held after clear");
        wr(3'd3, 32'h1);
        chk(32'(irq), 0, "R5 released");
        rd_exp(3'd6, 32'h0, "R10 undecoded address");

        // R6 halt master 0 with ordering
        wr(3'd1, 32'h0700_0000);
        wr(3'd4, 32'h1);
        chk(32'(queue_stop), 32'h1, "R6 queue_stop raised");
        rd_exp(3'd0, 32'h0, "R6 ack not yet");
        chk(32'(irq), 0, "R6 no irq before ack");
        idle(8);
        rd_exp(3'd0, 32'h0200_0000, "R6 ack bit25");
        chk(32'(irq), 1, "R6 irq on ack");
        rd_exp(3'd4, 32'h1, "R10 halt readback");
        clr_all();

        // R7 second halt ignored
        wr(3'd4, 32'h1);
        idle(8);
        rd_exp(3'd0, 32'h0, "R7 no second ack");
        chk(32'(queue_stop), 32'h1, "R7 still stopped");

        // R6 master 1
        wr(3'd4, 32'h2);
        idle(8);
        rd_exp(3'd0, 32'h0400_0000, "R6 ack bit26");
        chk(32'(queue_stop), 32'h3, "R6 both stopped");
        clr_all();

        // R8 reset master 0 only
        wr(3'd5, 32'h0000_03F1);
        chk(32'(master_rst), 32'h1, "R8 master0 reset pulse");
        idle(6);
        chk(32'(queue_stop), 32'h2, "R8 master0 released");
        rd_exp(3'd0, 32'h0100_0000, "R8 reset done bit24");
        clr_all();

        // R9 bad reset word
        wr(3'd5, 32'h1234_5678);
        chk(32'(master_rst), 0, "R9 no reset pulse");
        idle(6);
        rd_exp(3'd0, 32'h0, "R9 no reset done");
        chk(32'(queue_stop), 32'h2, "R9 stop unchanged");

        // R8 full reset
        wr(3'd5, 32'h0F73_F3F7);
        chk(32'(master_rst), 32'h3, "R8 full reset pulse");
        idle(6);
        chk(32'(queue_stop), 32'h0, "R8 all released");
        rd_exp(3'd0, 32'h0100_0000, "R8 full reset done");
        clr_all();

        // R8 reset master 1 only after halting it
        wr(3'd4, 32'h2);
        idle(8);
        clr_all();
        wr(3'd5, 32'h0003_F001);
        chk(32'(master_rst), 32'h2, "R8 master1 reset pulse");
        idle(6);
        chk(32'(queue_stop), 32'h0, "R8 master1 released");
        rd_exp(3'd0, 32'h0100_0000, "R8 master1 reset done");

        idle(5);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule